// File: doc/BRIEF.md
# Timer Input Capture Unit

This block timestamps pin transitions against a shared free-running 16-bit count. It has three channels. Each channel watches one already-synchronized input pin. When the edge chosen for that channel appears, the channel copies the count value of that cycle into its own 16-bit capture register and raises its status flag. Software reaches the unit through a small byte-wide register bus. On that bus it reads each timestamp as a high byte and a low byte, programs the edge choice of every channel, sets the interrupt enables and clears flags. The counter, its prescaler and the pin synchronizers sit outside this block.

A read of a channel's capture register may fall in the cycle that holds a new edge. In that case the channel must not overwrite the bytes being read. It parks the timestamp of that cycle and stays in state `CH_HELD`. It leaves that state, and commits the parked value and raises the flag, in the first cycle without a read to that channel. A channel with nothing parked sits in `CH_IDLE`. Three transitions exist:
- `CH_IDLE` to `CH_HELD`: an edge coincides with a read of that channel.
- `CH_HELD` to `CH_HELD`: reads of that channel continue.
- `CH_HELD` to `CH_IDLE`: the reads end and the parked value is committed.

In `CH_IDLE`, an edge with no read is committed at once.

The register map uses a 3-bit address:
- Addresses 0 to 5 are the capture bytes. Channel n has its high byte at 2n and its low byte at 2n+1.
- Address 6 is the edge-control register.
- Address 7 is the status/enable register.

Top module: `icu_capture_top`

## Requirements
- R1: Each channel captures the value on `tcnt` of the cycle in which its selected edge is seen. Captured values are visible from the clock edge at the end of that cycle. A capture on one channel leaves the other channels' registers and flags unchanged.
- R2: The edge-select field of channel n is bits [2n+1:2n] of address 6. The field reads back as written. Its codes are 00 for disabled, 01 for rising only, 10 for falling only and 11 for both edges. An unselected edge changes neither the capture register nor the flag.
- R3: A channel's flag becomes 1 on the same clock edge that stores its capture value. Flags appear on `cap_flag[n]` and in bits [2:0] of address 7.
- R4: A read at address 2n returns bits [15:8] of channel n's capture, and a read at 2n+1 returns bits [7:0]. `bus_rdata` is valid in the cycle after `bus_rd` and holds its value until the next read.
- R5: Writes to addresses 0 to 5 change no capture register.
- R6: During any cycle in which channel n's capture bytes are read, a new capture for that channel is held off. The count value of the edge cycle is stored, and the flag raised, on the first following cycle without such a read. The capture is never lost.
- R7: Writing 1 to bit n of address 7 clears flag n. Writing 0 leaves it unchanged. If a capture and a clear of the same flag fall in one cycle, the flag ends at 1.
- R8: Bits [6:4] of address 7 are the interrupt enables for channels 0 to 2. Every write to address 7 loads them, and they read back in the same position.
- R9: `cap_irq` is 1 exactly when some channel has both its flag and its enable at 1.
- R10: After reset, all capture registers, flags, edge selects, enables, `bus_rdata` and `cap_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tcnt | input | 16 | Free-running count value |
| cap_pin | input | 3 | Synchronized capture inputs, one per channel |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe, one per cycle |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| cap_flag | output | 3 | Per-channel status flags |
| cap_irq | output | 1 | Interrupt request |

## Verification
Two functions of this block can fall in the same cycle. The first is a capture edge and a read of the same channel's bytes. The bench raises a pin in the very cycle it reads that channel. It checks three things: the flag stays 0 while reads continue, the read returns the old byte, and the stored value is the count of the edge cycle rather than a later one. The second is a capture commit and a write-one-to-clear of the same flag. The bench drives a pin edge together with the clear write and expects the flag to stay at 1 with the new timestamp in place.

// File: rtl/icu_pkg.sv
package icu_pkg;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_HELD = 1'b1
    } ch_state_t;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_t;

endpackage

// File: rtl/icu_edge.sv
module icu_edge
    import icu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] sel,
    output logic       strobe
);

    logic pin_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin;
    end

    assign rise = pin & ~pin_q;
    assign fall = ~pin & pin_q;

    always_comb begin
        unique case (edge_sel_t'(sel))
            EDGE_OFF:  strobe = 1'b0;
            EDGE_RISE: strobe = rise;
            EDGE_FALL: strobe = fall;
            EDGE_BOTH: strobe = rise | fall;
            default:   strobe = 1'b0;
        endcase
    end

endmodule

// File: rtl/icu_channel.sv
module icu_channel
    import icu_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] tcnt,
    input  logic          pin,
    input  logic [1:0]    sel,
    input  logic          rd_hit,
    input  logic          clr,
    output logic [CW-1:0] cap,
    output logic          flag,
    output logic          held
);

    ch_state_t     state_q;
    ch_state_t     state_d;
    logic          strobe;
    logic          commit;
    logic [CW-1:0] pend_q;
    logic [CW-1:0] stamp;

    icu_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin    (pin),
        .sel    (sel),
        .strobe (strobe)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (strobe && rd_hit) state_d = CH_HELD;
            CH_HELD: if (!rd_hit)          state_d = CH_IDLE;
            default:                       state_d = CH_IDLE;
        endcase
    end

    assign commit = !rd_hit && (strobe || (state_q == CH_HELD));
    assign stamp  = strobe ? tcnt : pend_q;
    assign held   = (state_q == CH_HELD);

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            cap    <= '0;
            flag   <= 1'b0;
        end else begin
            if (strobe && rd_hit) pend_q <= tcnt;
            if (commit)           cap    <= stamp;
            if (commit)           flag   <= 1'b1;
            else if (clr)         flag   <= 1'b0;
        end
    end

endmodule

// File: rtl/icu_regs.sv
module icu_regs #(
    parameter int NCH = 3,
    parameter int CW  = 16,
    parameter int AW  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic [NCH*CW-1:0] cap_flat,
    input  logic [NCH-1:0]    flags,
    output logic [7:0]        bus_rdata,
    output logic [2*NCH-1:0]  sel_flat,
    output logic [NCH-1:0]    en,
    output logic [NCH-1:0]    rd_hit,
    output logic [NCH-1:0]    clr
);

    localparam logic [AW-1:0] CTRL_A = AW'(2 * NCH);
    localparam logic [AW-1:0] STAT_A = AW'(2 * NCH + 1);

    logic [7:0] rd_next;

    for (genvar g = 0; g < NCH; g++) begin : g_dec
        assign rd_hit[g] = bus_rd && ((bus_addr == AW'(2 * g)) || (bus_addr == AW'(2 * g + 1)));
        assign clr[g]    = bus_wr && (bus_addr == STAT_A) && bus_wdata[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_flat <= '0;
            en       <= '0;
        end else if (bus_wr) begin
            if (bus_addr == CTRL_A) sel_flat <= bus_wdata[2*NCH-1:0];
            if (bus_addr == STAT_A) en       <= bus_wdata[4 +: NCH];
        end
    end

    always_comb begin
        rd_next = '0;
        for (int k = 0; k < NCH; k++) begin
            if (bus_addr == AW'(2 * k))     rd_next = cap_flat[k*CW + CW - 8 +: 8];
            if (bus_addr == AW'(2 * k + 1)) rd_next = cap_flat[k*CW +: 8];
        end
        if (bus_addr == CTRL_A) rd_next[2*NCH-1:0] = sel_flat;
        if (bus_addr == STAT_A) begin
            rd_next[NCH-1:0]  = flags;
            rd_next[4 +: NCH] = en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end

endmodule

// File: rtl/icu_capture_top.sv
module icu_capture_top #(
    parameter int NCH = 3,
    parameter int CW  = 16,
    localparam int AW = $clog2(2 * NCH + 2)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  tcnt,
    input  logic [NCH-1:0] cap_pin,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_rd,
    input  logic           bus_wr,
    input  logic [7:0]     bus_wdata,
    output logic [7:0]     bus_rdata,
    output logic [NCH-1:0] cap_flag,
    output logic           cap_irq
);

    logic [NCH*CW-1:0] cap_flat;
    logic [2*NCH-1:0]  sel_flat;
    logic [NCH-1:0]    en;
    logic [NCH-1:0]    rd_hit;
    logic [NCH-1:0]    clr;
    logic [NCH-1:0]    held;

    icu_regs #(.NCH(NCH), .CW(CW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .cap_flat  (cap_flat),
        .flags     (cap_flag),
        .bus_rdata (bus_rdata),
        .sel_flat  (sel_flat),
        .en        (en),
        .rd_hit    (rd_hit),
        .clr       (clr)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        icu_channel #(.CW(CW)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .tcnt   (tcnt),
            .pin    (cap_pin[g]),
            .sel    (sel_flat[2*g +: 2]),
            .rd_hit (rd_hit[g]),
            .clr    (clr[g]),
            .cap    (cap_flat[g*CW +: CW]),
            .flag   (cap_flag[g]),
            .held   (held[g])
        );
    end

    assign cap_irq = |(cap_flag & en);

endmodule

// File: rtl/icu_capture_chk.sv
module icu_capture_chk #(
    parameter int NCH = 3,
    parameter int CW  = 16,
    parameter int AW  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [AW-1:0]     bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [NCH-1:0]    cap_flag,
    input logic [NCH*CW-1:0] cap_flat,
    input logic [2*NCH-1:0]  sel_flat,
    input logic [NCH-1:0]    rd_hit,
    input logic [NCH-1:0]    held
);

    localparam logic [AW-1:0] STAT_A = AW'(2 * NCH + 1);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R6
        held_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_hit[g] |=> !$rose(cap_flag[g]) && $stable(cap_flat[g*CW +: CW]));

        // R3
        cap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(cap_flat[g*CW +: CW]) |-> cap_flag[g]);

        // R7
        zero_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_flag[g] && !(bus_wr && (bus_addr == STAT_A) && bus_wdata[g])) |=> cap_flag[g]);

        // R2
        off_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!held[g] && (sel_flat[2*g +: 2] == 2'b00)) |=> !$rose(cap_flag[g]));
    end

endmodule

bind icu_capture_top icu_capture_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cap_flag  (cap_flag),
    .cap_flat  (cap_flat),
    .sel_flat  (sel_flat),
    .rd_hit    (rd_hit),
    .held      (held)
);

// File: tb/sim_icu_capture_top.sv
`timescale 1ns/1ps
module sim_icu_capture_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] tcnt;
    logic [2:0]  cap_pin;
    logic [2:0]  bus_addr;
    logic        bus_rd;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic [2:0]  cap_flag;
    logic        cap_irq;

    int total = 0;
    int fails = 0;
    bit done  = 0;
    logic rd_seen = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t q[$];

    always #5 clk = ~clk;

    icu_capture_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tcnt      (tcnt),
        .cap_pin   (cap_pin),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cap_flag  (cap_flag),
        .cap_irq   (cap_irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per completed read
    always @(posedge clk) rd_seen <= bus_rd && rst_n;

    always @(negedge clk) begin
        if (rd_seen) begin
            item_t it;
            total++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL R4 unexpected read actual=%h expected=none", bus_rdata);
            end else begin
                it = q.pop_front();
                if (bus_rdata !== it.exp) begin
                    fails++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    // driver tasks: all start and end just after a falling edge
    task automatic bus_read(input logic [2:0] a, input logic [7:0] exp, input string tag);
        item_t it;
        it.exp = exp;
        it.tag = tag;
        q.push_back(it);
        bus_rd   = 1'b1;
        bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pin_set(input int ch, input logic lvl, input logic [15:0] t);
        tcnt        = t;
        cap_pin[ch] = lvl;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL R1 watchdog expired actual=running expected=finished");
            summary();
        end
    end

    initial begin
        rst_n = 1'b0; tcnt = '0; cap_pin = '0;
        bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        check("R10 flags", 16'(cap_flag), 16'h0);
        check("R10 irq", 16'(cap_irq), 16'h0);
        check("R10 rdata", 16'(bus_rdata), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(3'd0, 8'h00, "R10 cap0 hi");
        bus_read(3'd7, 8'h00, "R10 status");

        // R2: ch0 rising, ch1 falling, ch2 both
        bus_write(3'd6, 8'h39);
        bus_read(3'd6, 8'h39, "R2 edge ctrl readback");

        // R1 R3: ch0 rising capture
        pin_set(0, 1'b1, 16'h1234);
        check("R3 flag0 set", 16'(cap_flag), 16'h1);
        bus_read(3'd0, 8'h12, "R1 R4 cap0 hi");
        bus_read(3'd1, 8'h34, "R1 R4 cap0 lo");

        // R7: clear flag0
        bus_write(3'd7, 8'h01);
        check("R7 flag0 cleared", 16'(cap_flag), 16'h0);

        // R2: falling edge ignored on rising-only ch0
        pin_set(0, 1'b0, 16'h5555);
        check("R2 ch0 falling ignored flag", 16'(cap_flag), 16'h0);
        bus_read(3'd1, 8'h34, "R2 ch0 falling ignored cap");

        // R2: ch1 falling only
        pin_set(1, 1'b1, 16'h1111);
        check("R2 ch1 rising ignored", 16'(cap_flag), 16'h0);
        pin_set(1, 1'b0, 16'h2222);
        check("R2 ch1 falling captured", 16'(cap_flag), 16'h2);
        bus_read(3'd2, 8'h22, "R2 cap1 hi");
        bus_read(3'd3, 8'h22, "R2 cap1 lo");
        bus_read(3'd0, 8'h12, "R1 cap0 untouched by ch1");

        // R2: ch2 both edges
        pin_set(2, 1'b1, 16'hABCD);
        check("R2 ch2 rising captured", 16'(cap_flag), 16'h6);
        bus_read(3'd4, 8'hAB, "R2 cap2 rise hi");
        pin_set(2, 1'b0, 16'h0F0E);
        bus_read(3'd4, 8'h0F, "R2 cap2 fall hi");
        bus_read(3'd5, 8'h0E, "R2 cap2 fall lo");

        // R2: ch0 disabled
        bus_write(3'd6, 8'h38);
        pin_set(0, 1'b1, 16'h7A7A);
        pin_set(0, 1'b0, 16'h7B7B);
        check("R2 ch0 disabled flag", 16'(cap_flag), 16'h6);
        bus_read(3'd1, 8'h34, "R2 ch0 disabled cap");

        // R7: writing zeros leaves flags
        bus_write(3'd7, 8'h00);
        check("R7 zero write keeps flags", 16'(cap_flag), 16'h6);

        // R8 R9: enable ch1
        check("R9 irq off without enables", 16'(cap_irq), 16'h0);
        bus_write(3'd7, 8'h20);
        check("R9 irq on", 16'(cap_irq), 16'h1);
        bus_read(3'd7, 8'h26, "R8 status readback");
        bus_write(3'd7, 8'h22);
        check("R9 irq off after clear", 16'(cap_irq), 16'h0);
        check("R7 flag1 cleared", 16'(cap_flag), 16'h4);

        // R5: capture bytes not writable
        bus_write(3'd4, 8'hFF);
        bus_write(3'd5, 8'hFF);
        bus_read(3'd4, 8'h0F, "R5 cap2 hi after write");
        bus_read(3'd5, 8'h0E, "R5 cap2 lo after write");

        // R6: edge in a read cycle is deferred one cycle
        bus_write(3'd6, 8'h39);
        begin
            item_t it;
            it.exp = 8'h12; it.tag = "R6 read during edge returns old";
            q.push_back(it);
            bus_rd = 1'b1; bus_addr = 3'd0; cap_pin[0] = 1'b1; tcnt = 16'h4242;
            @(negedge clk);
            bus_rd = 1'b0; tcnt = 16'h9999;
            check("R6 flag0 held off", 16'(cap_flag), 16'h4);
            @(negedge clk);
            check("R6 flag0 after deferral", 16'(cap_flag), 16'h5);
        end
        bus_read(3'd0, 8'h42, "R6 deferred cap hi");
        bus_read(3'd1, 8'h42, "R6 deferred cap lo");

        // R6: deferral across three consecutive read cycles
        bus_write(3'd7, 8'h21);
        pin_set(0, 1'b0, 16'h0000);
        begin
            item_t it;
            it.exp = 8'h42; it.tag = "R6 long hold read 1";
            q.push_back(it);
            bus_rd = 1'b1; bus_addr = 3'd1; cap_pin[0] = 1'b1; tcnt = 16'h7777;
            @(negedge clk);
            it.tag = "R6 long hold read 2";
            q.push_back(it);
            tcnt = 16'h8888;
            check("R6 flag0 held 1", 16'(cap_flag), 16'h4);
            @(negedge clk);
            it.tag = "R6 long hold read 3";
            q.push_back(it);
            bus_addr = 3'd0; tcnt = 16'h9999;
            check("R6 flag0 held 2", 16'(cap_flag), 16'h4);
            @(negedge clk);
            bus_rd = 1'b0;
            check("R6 flag0 held 3", 16'(cap_flag), 16'h4);
            @(negedge clk);
            check("R6 flag0 after long hold", 16'(cap_flag), 16'h5);
        end
        bus_read(3'd0, 8'h77, "R6 long hold cap hi");
        bus_read(3'd1, 8'h77, "R6 long hold cap lo");

        // R7: capture and clear of flag2 in one cycle
        bus_wr = 1'b1; bus_addr = 3'd7; bus_wdata = 8'h24;
        cap_pin[2] = 1'b1; tcnt = 16'h3C3C;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R7 set beats clear", 16'(cap_flag), 16'h5);
        bus_read(3'd4, 8'h3C, "R7 cap2 hi on collision");
        bus_read(3'd5, 8'h3C, "R7 cap2 lo on collision");
        bus_write(3'd7, 8'h24);
        check("R7 flag2 cleared later", 16'(cap_flag), 16'h1);

        @(negedge clk);
        done = 1;
        summary();
    end

endmodule